// File: doc/BRIEF.md
# IDE DMA Transfer Sequencer

This block steers one DMA command between an IDE-style device and a descriptor-driven DMA channel. A start command fixes the transfer: it names the device type (fixed disk or packet/optical), the operation (read, write or trim), the starting block address, and the amount of data. The disk amount is a sector count of 512-byte sectors. The packet amount is a byte count. On start the sequencer computes the total byte budget, clears its progress index, raises its active flag and kicks the DMA channel.

The DMA channel then offers chunks, one at a time, each with a memory address and a byte length. The sequencer handles each chunk in one of these ways:
- It parks the chunk when no command is active.
- It finishes the command when the budget is already used up.
- It ends a zero-length chunk at once.
- It asks a copy engine to write packet data straight to memory when the packet command has no block address.
- Otherwise it asks the storage engine to move the chunk at a computed byte offset.

Both engines sit outside the block and are reached through request and acknowledge handshakes. A storage error takes the error path for the device type, and the chunk ends.

Top module: `ide_dma_seq`

## Requirements
- R1: A start that is accepted loads a byte budget of sector count × 512 for a disk, clears the progress index, sets `active`, and pulses `kick` in the cycle after the start. The same start clears `stat_ready`, `stat_seek`, `irq` and `illegal`.
- R2: A packet start (`cmd_pkt`=1) loads the budget from `cmd_pkt_size` in bytes, whatever the value of `cmd_kind`.
- R3: A chunk that arrives while `active` is low pulses `chunk_park` and issues no storage or copy request.
- R4: A disk chunk with a non-zero length and a remaining budget issues `st_req` with `st_offset` = LBA × 512 + progress index, `st_len` = chunk length and `st_addr` = chunk address. `st_op` carries the command code: 0 read, 1 write, 2 trim. The request is held, with a stable offset, until `st_ack`.
- R5: A packet chunk with a block address issues a read (`st_op`=0) at `st_offset` = LBA × 2048 + progress index.
- R6: Each issued chunk subtracts its length from the budget and adds it to the progress index, so the next chunk's offset moves on by the previous length.
- R7: On a good `st_ack`, if the budget is now ≤ 0, a disk command sets `stat_ready`, `stat_seek` and `irq`, and clears `active`. In every case `chunk_end` pulses.
- R8: A packet command that completes pulses `pkt_ok`, leaves `irq` low, and clears `active`.
- R9: A zero-length chunk while the budget is still positive pulses `chunk_end` only: no request is made and `active` stays high.
- R10: A packet command whose LBA is all ones raises `cp_req` with `cp_len` = min(budget, chunk length) and `cp_addr` = chunk address. On `cp_ack` it pulses `pkt_ok` and `chunk_end` and clears `active`. `st_req` and `cp_req` are never high together.
- R11: A `st_ack` with `st_err` high pulses `dma_err` for a disk or `pkt_err` for a packet command, pulses `chunk_end`, and clears `active`.
- R12: A disk start with `cmd_kind`=3 is refused: `illegal` is set, no `kick` is sent, and `active` stays low.
- R13: A chunk that arrives while active with a budget already ≤ 0 (for example after a sector count of zero) completes the command with no storage request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start a command (taken when idle) |
| cmd_pkt | input | 1 | 1 = packet device, 0 = disk |
| cmd_kind | input | 2 | 0 read, 1 write, 2 trim, 3 illegal |
| cmd_lba | input | LBA_W | Starting block address |
| cmd_count | input | CNT_W | Disk sector count |
| cmd_pkt_size | input | SIZE_W | Packet transfer size in bytes |
| kick | output | 1 | Pulse that starts the DMA channel |
| active | output | 1 | Command in progress |
| chunk_valid | input | 1 | DMA chunk offered |
| chunk_addr | input | ADDR_W | Chunk memory address |
| chunk_len | input | LEN_W | Chunk byte length |
| chunk_end | output | 1 | Pulse: chunk finished |
| chunk_park | output | 1 | Pulse: chunk held for a restart |
| st_req | output | 1 | Storage transfer request |
| st_op | output | 2 | Storage operation code |
| st_offset | output | OFF_W | Storage byte offset |
| st_len | output | LEN_W | Storage byte length |
| st_addr | output | ADDR_W | Memory address for the storage transfer |
| st_ack | input | 1 | Storage transfer done |
| st_err | input | 1 | Error flag with `st_ack` |
| cp_req | output | 1 | Direct memory copy request |
| cp_addr | output | ADDR_W | Copy destination address |
| cp_len | output | LEN_W | Copy byte length |
| cp_ack | input | 1 | Copy done |
| stat_ready | output | 1 | Device ready status bit |
| stat_seek | output | 1 | Seek complete status bit |
| irq | output | 1 | Disk completion interrupt |
| pkt_ok | output | 1 | Pulse: packet command OK |
| dma_err | output | 1 | Pulse: disk DMA error |
| pkt_err | output | 1 | Pulse: packet I/O error |
| illegal | output | 1 | Illegal command code seen |

## Verification
The main path is driven from a vector table. It mixes disk reads, writes and trims, single packet chunks, storage errors, and a block address large enough that the offset crosses 32 bits. Between them, the vectors separate the two offset scalings, the op codes passed through, and the error routing by device type. They also separate completing from ending a chunk while the budget is still open. Directed runs then split a disk transfer into two chunks to expose the progress index. They also cover the cases that stop before any storage request: a parked chunk, a zero-length chunk, a zero sector count, the copy path on both sides of the min(), and an illegal code.

// File: rtl/ide_dma_seq_pkg.sv
package ide_dma_seq_pkg;
  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_TRIM  = 2'd2;
  localparam logic [1:0] OP_BAD   = 2'd3;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_STORE = 2'd1,
    S_COPY  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ide_dma_seq_base.sv
module ide_dma_seq_base #(
  parameter int LBA_W   = 32,
  parameter int CNT_W   = 16,
  parameter int SIZE_W  = 32,
  parameter int OFF_W   = 48,
  parameter int REM_W   = 34,
  parameter int SECT_SH = 9,
  parameter int PKT_SH  = 11
) (
  input  logic             is_pkt,
  input  logic [LBA_W-1:0] lba,
  input  logic [CNT_W-1:0] count,
  input  logic [SIZE_W-1:0] pkt_size,
  output logic [OFF_W-1:0] base_off,
  output logic [REM_W-1:0] init_rem,
  output logic             no_lba
);
  always_comb begin
    if (is_pkt) begin
      base_off = OFF_W'(lba) << PKT_SH;
      init_rem = REM_W'(pkt_size);
    end else begin
      base_off = OFF_W'(lba) << SECT_SH;
      init_rem = REM_W'(count) << SECT_SH;
    end
    no_lba = is_pkt && (&lba);
  end
endmodule

// File: rtl/ide_dma_seq_track.sv
module ide_dma_seq_track #(
  parameter int OFF_W = 48,
  parameter int REM_W = 34,
  parameter int LEN_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [OFF_W-1:0]        base_in,
  input  logic [REM_W-1:0]        rem_in,
  input  logic                    no_lba_in,
  input  logic                    step,
  input  logic [LEN_W-1:0]        step_len,
  output logic [OFF_W-1:0]        base_off,
  output logic signed [REM_W-1:0] remain,
  output logic [REM_W-1:0]        index,
  output logic                    no_lba,
  output logic                    rem_done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base_off <= '0;
      remain   <= '0;
      index    <= '0;
      no_lba   <= 1'b0;
    end else if (load) begin
      base_off <= base_in;
      remain   <= rem_in;
      index    <= '0;
      no_lba   <= no_lba_in;
    end else if (step) begin
      remain <= remain - REM_W'(step_len);
      index  <= index + REM_W'(step_len);
    end
  end

  assign rem_done = remain[REM_W-1] || (remain == '0);

  // R6: the progress index only grows on a step of non-zero length
  assert_index_grows_R6: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (index > $past(index)));
  // R1: a load always restarts the progress index
  assert_load_clears_R1: assert property (@(posedge clk) disable iff (rst)
    load |=> (index == '0));
endmodule

// File: rtl/ide_dma_seq_ctrl.sv
module ide_dma_seq_ctrl
  import ide_dma_seq_pkg::*;
#(
  parameter int OFF_W  = 48,
  parameter int REM_W  = 34,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cmd_start,
  input  logic                    cmd_pkt,
  input  logic [1:0]              cmd_kind,
  input  logic                    chunk_valid,
  input  logic [ADDR_W-1:0]       chunk_addr,
  input  logic [LEN_W-1:0]        chunk_len,
  input  logic                    st_ack,
  input  logic                    st_err,
  input  logic                    cp_ack,
  input  logic [OFF_W-1:0]        base_off,
  input  logic signed [REM_W-1:0] remain,
  input  logic [REM_W-1:0]        index,
  input  logic                    no_lba,
  input  logic                    rem_done,
  output logic                    load,
  output logic                    step,
  output logic                    kick,
  output logic                    active,
  output logic                    chunk_end,
  output logic                    chunk_park,
  output logic                    st_req,
  output logic [1:0]              st_op,
  output logic [OFF_W-1:0]        st_offset,
  output logic [LEN_W-1:0]        st_len,
  output logic [ADDR_W-1:0]       st_addr,
  output logic                    cp_req,
  output logic [ADDR_W-1:0]       cp_addr,
  output logic [LEN_W-1:0]        cp_len,
  output logic                    stat_ready,
  output logic                    stat_seek,
  output logic                    irq,
  output logic                    pkt_ok,
  output logic                    dma_err,
  output logic                    pkt_err,
  output logic                    illegal
);
  seq_state_e state;
  logic       pkt_r;
  logic [1:0] kind_r;
  logic       idle, start_ok, issue, len_zero, copy_path, rem_short;

  assign idle      = (state == S_IDLE);
  assign start_ok  = cmd_pkt || (cmd_kind != OP_BAD);
  assign load      = idle && cmd_start && start_ok;
  assign len_zero  = (chunk_len == '0);
  assign copy_path = pkt_r && no_lba;
  assign issue     = idle && !cmd_start && chunk_valid && active && !rem_done && !len_zero;
  assign step      = issue && !copy_path;
  assign rem_short = remain < $signed(REM_W'(chunk_len));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      pkt_r      <= 1'b0;
      kind_r     <= OP_READ;
      kick       <= 1'b0;
      active     <= 1'b0;
      chunk_end  <= 1'b0;
      chunk_park <= 1'b0;
      st_req     <= 1'b0;
      st_op      <= OP_READ;
      st_offset  <= '0;
      st_len     <= '0;
      st_addr    <= '0;
      cp_req     <= 1'b0;
      cp_addr    <= '0;
      cp_len     <= '0;
      stat_ready <= 1'b0;
      stat_seek  <= 1'b0;
      irq        <= 1'b0;
      pkt_ok     <= 1'b0;
      dma_err    <= 1'b0;
      pkt_err    <= 1'b0;
      illegal    <= 1'b0;
    end else begin
      kick       <= 1'b0;
      chunk_end  <= 1'b0;
      chunk_park <= 1'b0;
      pkt_ok     <= 1'b0;
      dma_err    <= 1'b0;
      pkt_err    <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (cmd_start) begin
            stat_ready <= 1'b0;
            stat_seek  <= 1'b0;
            irq        <= 1'b0;
            pkt_r      <= cmd_pkt;
            kind_r     <= cmd_kind;
            if (start_ok) begin
              illegal <= 1'b0;
              active  <= 1'b1;
              kick    <= 1'b1;
            end else begin
              illegal <= 1'b1;
              active  <= 1'b0;
            end
          end else if (chunk_valid) begin
            if (!active) begin
              chunk_park <= 1'b1;
            end else if (rem_done) begin
              if (pkt_r) begin
                pkt_ok <= 1'b1;
              end else begin
                stat_ready <= 1'b1;
                stat_seek  <= 1'b1;
                irq        <= 1'b1;
              end
              active    <= 1'b0;
              chunk_end <= 1'b1;
            end else if (len_zero) begin
              chunk_end <= 1'b1;
            end else if (copy_path) begin
              cp_req  <= 1'b1;
              cp_addr <= chunk_addr;
              cp_len  <= rem_short ? remain[LEN_W-1:0] : chunk_len;
              state   <= S_COPY;
            end else begin
              st_req    <= 1'b1;
              st_op     <= pkt_r ? OP_READ : kind_r;
              st_offset <= base_off + OFF_W'(index);
              st_len    <= chunk_len;
              st_addr   <= chunk_addr;
              state     <= S_STORE;
            end
          end
        end
        S_STORE: begin
          if (st_ack) begin
            st_req    <= 1'b0;
            state     <= S_IDLE;
            chunk_end <= 1'b1;
            if (st_err) begin
              if (pkt_r) pkt_err <= 1'b1;
              else       dma_err <= 1'b1;
              active <= 1'b0;
            end else if (rem_done) begin
              if (pkt_r) begin
                pkt_ok <= 1'b1;
              end else begin
                stat_ready <= 1'b1;
                stat_seek  <= 1'b1;
                irq        <= 1'b1;
              end
              active <= 1'b0;
            end
          end
        end
        S_COPY: begin
          if (cp_ack) begin
            cp_req    <= 1'b0;
            pkt_ok    <= 1'b1;
            active    <= 1'b0;
            chunk_end <= 1'b1;
            state     <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3: a parked chunk only ever occurs without an active command
  assert_park_inactive_R3: assert property (@(posedge clk) disable iff (rst)
    chunk_park |-> !active);
  // R4: a storage request holds its offset until acknowledged
  assert_store_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (st_req && !st_ack) |=> (st_req && $stable(st_offset)));
  // R10: the two engine requests are exclusive
  assert_req_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(st_req && cp_req));
  // R7: the interrupt rises together with both status bits
  assert_irq_status_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (stat_ready && stat_seek));
  // R9: a chunk is either ended or parked, never both
  assert_end_or_park_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({chunk_end, chunk_park}));
  // R12: a refused command never becomes active
  assert_illegal_idle_R12: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!active && !kick));
  // R8: packet completion never raises the disk interrupt
  assert_pkt_no_irq_R8: assert property (@(posedge clk) disable iff (rst)
    (pkt_ok && pkt_r) |-> !$rose(irq));
endmodule

// File: rtl/ide_dma_seq.sv
module ide_dma_seq
  import ide_dma_seq_pkg::*;
#(
  parameter int LBA_W   = 32,
  parameter int CNT_W   = 16,
  parameter int SIZE_W  = 32,
  parameter int LEN_W   = 16,
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 48,
  parameter int SECT_SH = 9,
  parameter int PKT_SH  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic              cmd_pkt,
  input  logic [1:0]        cmd_kind,
  input  logic [LBA_W-1:0]  cmd_lba,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic [SIZE_W-1:0] cmd_pkt_size,
  output logic              kick,
  output logic              active,
  input  logic              chunk_valid,
  input  logic [ADDR_W-1:0] chunk_addr,
  input  logic [LEN_W-1:0]  chunk_len,
  output logic              chunk_end,
  output logic              chunk_park,
  output logic              st_req,
  output logic [1:0]        st_op,
  output logic [OFF_W-1:0]  st_offset,
  output logic [LEN_W-1:0]  st_len,
  output logic [ADDR_W-1:0] st_addr,
  input  logic              st_ack,
  input  logic              st_err,
  output logic              cp_req,
  output logic [ADDR_W-1:0] cp_addr,
  output logic [LEN_W-1:0]  cp_len,
  input  logic              cp_ack,
  output logic              stat_ready,
  output logic              stat_seek,
  output logic              irq,
  output logic              pkt_ok,
  output logic              dma_err,
  output logic              pkt_err,
  output logic              illegal
);
  localparam int REM_W = ((SIZE_W > CNT_W + SECT_SH) ? SIZE_W : CNT_W + SECT_SH) + 2;

  logic [OFF_W-1:0]        base_nxt, base_off;
  logic [REM_W-1:0]        rem_nxt, index;
  logic signed [REM_W-1:0] remain;
  logic                    no_lba_nxt, no_lba, rem_done, load, step;

  ide_dma_seq_base #(
    .LBA_W(LBA_W), .CNT_W(CNT_W), .SIZE_W(SIZE_W), .OFF_W(OFF_W),
    .REM_W(REM_W), .SECT_SH(SECT_SH), .PKT_SH(PKT_SH)
  ) u_base (
    .is_pkt(cmd_pkt), .lba(cmd_lba), .count(cmd_count), .pkt_size(cmd_pkt_size),
    .base_off(base_nxt), .init_rem(rem_nxt), .no_lba(no_lba_nxt)
  );

  ide_dma_seq_track #(.OFF_W(OFF_W), .REM_W(REM_W), .LEN_W(LEN_W)) u_track (
    .clk(clk), .rst(rst), .load(load), .base_in(base_nxt), .rem_in(rem_nxt),
    .no_lba_in(no_lba_nxt), .step(step), .step_len(chunk_len),
    .base_off(base_off), .remain(remain), .index(index), .no_lba(no_lba),
    .rem_done(rem_done)
  );

  ide_dma_seq_ctrl #(
    .OFF_W(OFF_W), .REM_W(REM_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_pkt(cmd_pkt),
    .cmd_kind(cmd_kind), .chunk_valid(chunk_valid), .chunk_addr(chunk_addr),
    .chunk_len(chunk_len), .st_ack(st_ack), .st_err(st_err), .cp_ack(cp_ack),
    .base_off(base_off), .remain(remain), .index(index), .no_lba(no_lba),
    .rem_done(rem_done), .load(load), .step(step), .kick(kick), .active(active),
    .chunk_end(chunk_end), .chunk_park(chunk_park), .st_req(st_req),
    .st_op(st_op), .st_offset(st_offset), .st_len(st_len), .st_addr(st_addr),
    .cp_req(cp_req), .cp_addr(cp_addr), .cp_len(cp_len),
    .stat_ready(stat_ready), .stat_seek(stat_seek), .irq(irq),
    .pkt_ok(pkt_ok), .dma_err(dma_err), .pkt_err(pkt_err), .illegal(illegal)
  );

  // R1: a kick always follows an accepted start and leaves the command active
  assert_kick_active_R1: assert property (@(posedge clk) disable iff (rst)
    kick |-> active);
  // R11: an error pulse always comes with the end of the chunk
  assert_err_ends_R11: assert property (@(posedge clk) disable iff (rst)
    (dma_err || pkt_err) |-> (chunk_end && !active));
endmodule

// File: tb/ide_dma_seq_tb.sv
module ide_dma_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;
  localparam int NVEC       = 7;
  // {pkt, kind[1:0], err, lba[31:0], size[31:0], len[15:0]}
  localparam logic [83:0] VEC [NVEC] = '{
    {1'b0, 2'd0, 1'b0, 32'd5,          32'd1,    16'd512},
    {1'b0, 2'd1, 1'b0, 32'h10,         32'd2,    16'd512},
    {1'b0, 2'd2, 1'b0, 32'd3,          32'd1,    16'd1024},
    {1'b0, 2'd0, 1'b1, 32'd7,          32'd1,    16'd512},
    {1'b1, 2'd1, 1'b0, 32'd2,          32'd2048, 16'd2048},
    {1'b1, 2'd0, 1'b1, 32'd1,          32'd4096, 16'd2048},
    {1'b0, 2'd0, 1'b0, 32'h0080_0000,  32'd4,    16'd512}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_start = 1'b0, cmd_pkt = 1'b0;
  logic [1:0]  cmd_kind = 2'd0;
  logic [31:0] cmd_lba = '0;
  logic [15:0] cmd_count = '0;
  logic [31:0] cmd_pkt_size = '0;
  logic        chunk_valid = 1'b0;
  logic [31:0] chunk_addr = '0;
  logic [15:0] chunk_len = '0;
  logic        st_ack = 1'b0, st_err = 1'b0, cp_ack = 1'b0;
  logic        kick, active, chunk_end, chunk_park, st_req, cp_req;
  logic [1:0]  st_op;
  logic [47:0] st_offset;
  logic [15:0] st_len, cp_len;
  logic [31:0] st_addr, cp_addr;
  logic        stat_ready, stat_seek, irq, pkt_ok, dma_err, pkt_err, illegal;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ide_dma_seq u_dut (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_pkt(cmd_pkt),
    .cmd_kind(cmd_kind), .cmd_lba(cmd_lba), .cmd_count(cmd_count),
    .cmd_pkt_size(cmd_pkt_size), .kick(kick), .active(active),
    .chunk_valid(chunk_valid), .chunk_addr(chunk_addr), .chunk_len(chunk_len),
    .chunk_end(chunk_end), .chunk_park(chunk_park), .st_req(st_req),
    .st_op(st_op), .st_offset(st_offset), .st_len(st_len), .st_addr(st_addr),
    .st_ack(st_ack), .st_err(st_err), .cp_req(cp_req), .cp_addr(cp_addr),
    .cp_len(cp_len), .cp_ack(cp_ack), .stat_ready(stat_ready),
    .stat_seek(stat_seek), .irq(irq), .pkt_ok(pkt_ok), .dma_err(dma_err),
    .pkt_err(pkt_err), .illegal(illegal)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic pkt, input logic [1:0] kind, input logic [31:0] lba,
                          input logic [15:0] cnt, input logic [31:0] size);
    cmd_start = 1'b1; cmd_pkt = pkt; cmd_kind = kind; cmd_lba = lba;
    cmd_count = cnt; cmd_pkt_size = size;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic send_chunk(input logic [31:0] addr, input logic [15:0] len);
    chunk_valid = 1'b1; chunk_addr = addr; chunk_len = len;
    @(negedge clk);
    chunk_valid = 1'b0;
  endtask

  task automatic ack_store(input logic err);
    st_ack = 1'b1; st_err = err;
    @(negedge clk);
    st_ack = 1'b0; st_err = 1'b0;
  endtask

  task automatic ack_copy();
    cp_ack = 1'b1;
    @(negedge clk);
    cp_ack = 1'b0;
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    check("R1 reset active", active, 0);
    check("R1 reset irq", irq, 0);
    check("R4 reset st_req", st_req, 0);
    check("R10 reset cp_req", cp_req, 0);
    check("R12 reset illegal", illegal, 0);

    // R3: chunk with no command parks
    send_chunk(32'h40, 16'd512);
    check("R3 park", chunk_park, 1);
    check("R3 no st_req", st_req, 0);
    check("R3 no chunk_end", chunk_end, 0);

    // table of single-chunk commands: R1 R2 R4 R5 R7 R8 R11
    for (int i = 0; i < NVEC; i++) begin
      logic [83:0] v;
      logic pkt, err, done;
      logic [1:0] kind;
      logic [31:0] lba, size, addr;
      logic [15:0] len;
      longint rem0, off;
      v = VEC[i];
      pkt = v[83]; kind = v[82:81]; err = v[80];
      lba = v[79:48]; size = v[47:16]; len = v[15:0];
      addr = 32'h1000 * (i + 1);
      rem0 = pkt ? longint'(size) : longint'(size[15:0]) * 512;
      off  = pkt ? longint'(lba) * 2048 : longint'(lba) * 512;
      done = (rem0 - longint'(len)) <= 0;
      do_start(pkt, kind, lba, size[15:0], size);
      check("R1 kick", kick, 1);
      check("R1 active", active, 1);
      check("R1 irq cleared", irq, 0);
      send_chunk(addr, len);
      check("R4 st_req", st_req, 1);
      check(pkt ? "R5 offset" : "R4 offset", st_offset, 64'(off));
      check("R4 st_op", st_op, pkt ? 2'd0 : kind);
      check("R4 st_len", st_len, len);
      check("R4 st_addr", st_addr, addr);
      ack_store(err);
      check("R7 chunk_end", chunk_end, 1);
      check("R4 st_req drop", st_req, 0);
      if (err) begin
        check("R11 dma_err", dma_err, !pkt);
        check("R11 pkt_err", pkt_err, pkt);
        check("R11 inactive", active, 0);
      end else if (done) begin
        check(pkt ? "R8 irq low" : "R7 irq", irq, !pkt);
        check("R7 stat_ready", stat_ready, !pkt);
        check("R7 stat_seek", stat_seek, !pkt);
        check("R8 pkt_ok", pkt_ok, pkt);
        check("R7 inactive", active, 0);
      end else begin
        check("R7 no irq", irq, 0);
        check("R7 still active", active, 1);
      end
    end

    // R6: two chunks, the second offset advanced by the first length
    do_start(1'b0, 2'd1, 32'd1, 16'd2, 32'd0);
    send_chunk(32'h2000, 16'd512);
    check("R6 first offset", st_offset, 64'd512);
    ack_store(1'b0);
    check("R6 no irq mid", irq, 0);
    // R9: zero-length chunk in the middle
    send_chunk(32'h2200, 16'd0);
    check("R9 chunk_end", chunk_end, 1);
    check("R9 no st_req", st_req, 0);
    check("R9 still active", active, 1);
    send_chunk(32'h2400, 16'd512);
    check("R6 second offset", st_offset, 64'd1024);
    check("R6 second op write", st_op, 2'd1);
    ack_store(1'b0);
    check("R6 irq after last", irq, 1);
    check("R6 inactive", active, 0);

    // R13: zero sector count completes without a request
    do_start(1'b0, 2'd0, 32'd9, 16'd0, 32'd0);
    send_chunk(32'h3000, 16'd512);
    check("R13 no st_req", st_req, 0);
    check("R13 irq", irq, 1);
    check("R13 chunk_end", chunk_end, 1);
    check("R13 inactive", active, 0);

    // R10: no-LBA packet copy, budget smaller than chunk
    do_start(1'b1, 2'd0, 32'hFFFF_FFFF, 16'd0, 32'd100);
    send_chunk(32'h4000, 16'd512);
    check("R10 cp_req", cp_req, 1);
    check("R10 cp_len min budget", cp_len, 16'd100);
    check("R10 cp_addr", cp_addr, 32'h4000);
    check("R10 no st_req", st_req, 0);
    ack_copy();
    check("R10 pkt_ok", pkt_ok, 1);
    check("R10 chunk_end", chunk_end, 1);
    check("R10 inactive", active, 0);
    check("R10 cp_req drop", cp_req, 0);
    // R10: chunk smaller than budget
    do_start(1'b1, 2'd0, 32'hFFFF_FFFF, 16'd0, 32'd600);
    send_chunk(32'h5000, 16'd256);
    check("R10 cp_len min chunk", cp_len, 16'd256);
    ack_copy();
    check("R10 pkt_ok 2", pkt_ok, 1);

    // R2: packet start ignores kind code 3
    do_start(1'b1, 2'd3, 32'd4, 16'd0, 32'd2048);
    check("R2 kick", kick, 1);
    check("R2 no illegal", illegal, 0);
    send_chunk(32'h6000, 16'd2048);
    check("R2 read op", st_op, 2'd0);
    check("R2 offset", st_offset, 64'd8192);
    ack_store(1'b0);
    check("R2 budget used pkt_ok", pkt_ok, 1);

    // R12: illegal disk command
    do_start(1'b0, 2'd3, 32'd1, 16'd1, 32'd0);
    check("R12 illegal", illegal, 1);
    check("R12 no kick", kick, 0);
    check("R12 inactive", active, 0);
    send_chunk(32'h7000, 16'd512);
    check("R12 chunk parked", chunk_park, 1);
    check("R12 no st_req", st_req, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule